// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block owns the table of buffer descriptors shared by a frame transmitter and a frame receiver. Each descriptor is two 32-bit words: a status/length word, then a buffer address word. The table sits in the register space from byte offset 0x400, with descriptor i at 0x400 + 8*i. A programmable transmit count splits the table in two. Entries below the count form the transmit ring. The entries from the count up to the end of the table form the receive ring.

Software hands a transmit descriptor to the hardware by setting its ready bit, and a receive descriptor by setting its empty bit. The sequencer keeps one pointer per ring. It presents the current descriptor to the stubbed MAC engines. When an engine pulses that a frame is done, the sequencer writes the result bits (and, on receive, the length) into the status word and clears the ownership bit in the same write. It then raises the interrupt sources that apply and moves the pointer on, wrapping it back to the start of the ring where needed. Interrupt sources are write-1-to-clear, and the interrupt output is the OR of the sources that are masked in.

Top module: `bdring_seq`

## Requirements
- R1: After reset the source, mask and transmit count registers read 0, both ring pointers are 0, and irq and tx_ready are low.
- R2: A write to the transmit count register (byte 0x08) stores the value clamped to 0x80, and that clamped value reads back. The same write puts the transmit pointer at 0 and the receive pointer at the count.
- R3: Descriptor i is read and written at byte 0x400 + 8*i. Offset +0 holds the status word and offset +4 holds the buffer address.
- R4: tx_ready is high when the ring has at least one entry and bit 15 (ready) of the current transmit status is set. tx_buf_addr shows the descriptor's address word, tx_len shows bits 31:16, and tx_flags shows {bit 12 pad, bit 11 CRC}.
- R5: A tx_done pulse while tx_ready is high rewrites the current status. Bits 8:0 take tx_result, bit 15 is cleared, and bits 31:16 and 14:9 keep their old values.
- R6: On such a completion, if status bit 14 is set, source bit 1 (transmit error) is raised when tx_result has any of bits 0, 2, 3 or 8 set. Otherwise source bit 0 (transmit frame) is raised. When bit 14 is clear, no source changes.
- R7: After a transmit completion, the pointer returns to 0 if status bit 13 (wrap) was set or the entry was the last transmit entry. Otherwise it moves up by one.
- R8: rx_ready is high when the receive ring is non-empty and bit 15 (empty) of the current receive status is set, and rx_buf_addr shows the address word. An rx_done pulse while rx_ready is high writes rx_len to bits 31:16 and rx_status to bits 8:0, clears bit 15, and keeps bits 14:9.
- R9: On a receive completion with status bit 14 set, source bit 3 (receive error) is raised when rx_status has any of bits 0, 1, 2, 3, 5 or 6 set. Otherwise source bit 2 (receive frame) is raised.
- R10: After a receive completion, the pointer returns to the first receive index (equal to the count) if bit 13 was set or the entry was the last table entry. Otherwise it moves up by one.
- R11: An rx_done pulse while rx_ready is low raises source bit 4 (busy) whatever the descriptor holds, and leaves the receive pointer and the table unchanged.
- R12: A tx_done pulse while tx_ready is low leaves the transmit pointer, the table and the sources unchanged.
- R13: Writing 1s to the source register (byte 0x00) clears those bits, and a bit raised in the same cycle stays set. irq equals the OR of source AND mask, where the mask is at byte 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 11 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_ready | output | 1 | Current transmit descriptor is owned by hardware |
| tx_buf_addr | output | 32 | Buffer address of the current transmit descriptor |
| tx_len | output | 16 | Frame length of the current transmit descriptor |
| tx_flags | output | 2 | {pad, CRC} flags of the current transmit descriptor |
| tx_index | output | IDX_W | Transmit ring pointer |
| tx_done | input | 1 | Transmit engine finished a frame |
| tx_result | input | 9 | Transmit result bits |
| rx_ready | output | 1 | Current receive descriptor is empty |
| rx_buf_addr | output | 32 | Buffer address of the current receive descriptor |
| rx_index | output | IDX_W | Receive ring pointer (absolute table index) |
| rx_done | input | 1 | Receive engine finished a frame |
| rx_len | input | 16 | Received frame length |
| rx_status | input | 9 | Receive error and control bits |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches properties that hold on every cycle. It checks that the pointers stay inside their rings, that a receive frame with no empty descriptor raises busy without moving the pointer, that a transmit pulse with nothing ready changes nothing, and that a 1 written to the source register clears the bit. The bench scenarios show the rest: the exact status words written back, the choice between frame and error interrupts under the interrupt-enable bit, wrapping on the wrap bit against wrapping on the last index, and the clamped count readback.

// File: rtl/bdring_seq.sv
module bdring_seq #(
  parameter int NUM_BD    = 16,
  parameter int TXCNT_MAX = 128,
  localparam int IDX_W    = $clog2(NUM_BD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [10:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             tx_ready,
  output logic [31:0]      tx_buf_addr,
  output logic [15:0]      tx_len,
  output logic [1:0]       tx_flags,
  output logic [IDX_W-1:0] tx_index,
  input  logic             tx_done,
  input  logic [8:0]       tx_result,
  output logic             rx_ready,
  output logic [31:0]      rx_buf_addr,
  output logic [IDX_W-1:0] rx_index,
  input  logic             rx_done,
  input  logic [15:0]      rx_len,
  input  logic [8:0]       rx_status,
  output logic             irq
);
  logic [31:0]      stat_q [NUM_BD];
  logic [31:0]      addr_q [NUM_BD];
  logic [7:0]       cnt_q;
  logic [4:0]       src_q, mask_q;
  logic [IDX_W-1:0] tx_ptr, rx_ptr;

  wire             tbl_hit = reg_addr[10] && (reg_addr[9:IDX_W+3] == '0);
  wire [IDX_W-1:0] tbl_idx = reg_addr[IDX_W+2:3];
  wire             wr_src  = reg_wr && (reg_addr == 11'h000);
  wire             wr_mask = reg_wr && (reg_addr == 11'h004);
  wire             wr_cnt  = reg_wr && (reg_addr == 11'h008);

  wire [7:0] cnt_in  = (reg_wdata > 32'(TXCNT_MAX)) ? 8'(TXCNT_MAX) : reg_wdata[7:0];
  wire [7:0] txn     = (cnt_q  > 8'(NUM_BD)) ? 8'(NUM_BD) : cnt_q;
  wire [7:0] txn_new = (cnt_in > 8'(NUM_BD)) ? 8'(NUM_BD) : cnt_in;

  wire [31:0] tx_stat = stat_q[tx_ptr];
  wire [31:0] rx_stat = stat_q[rx_ptr];

  assign tx_ready    = (txn != 8'd0) && tx_stat[15];
  assign rx_ready    = (txn < 8'(NUM_BD)) && rx_stat[15];
  assign tx_buf_addr = addr_q[tx_ptr];
  assign tx_len      = tx_stat[31:16];
  assign tx_flags    = tx_stat[12:11];
  assign rx_buf_addr = addr_q[rx_ptr];
  assign tx_index    = tx_ptr;
  assign rx_index    = rx_ptr;

  wire tx_go   = tx_done && tx_ready;
  wire rx_go   = rx_done && rx_ready;
  wire tx_last = tx_stat[13] || (8'(tx_ptr) == txn - 8'd1);
  wire rx_last = rx_stat[13] || (rx_ptr == IDX_W'(NUM_BD - 1));
  wire tx_bad  = |(tx_result & 9'h10D);
  wire rx_bad  = |(rx_status & 9'h06F);

  wire [4:0] src_set = {rx_done && !rx_ready,
                        rx_go && rx_stat[14] && rx_bad,
                        rx_go && rx_stat[14] && !rx_bad,
                        tx_go && tx_stat[14] && tx_bad,
                        tx_go && tx_stat[14] && !tx_bad};

  assign irq = |(src_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
      tx_ptr <= '0;
      rx_ptr <= '0;
    end else begin
      src_q <= (src_q & ~(wr_src ? reg_wdata[4:0] : 5'b0)) | src_set;
      if (wr_mask) mask_q <= reg_wdata[4:0];
      if (wr_cnt) begin
        cnt_q  <= cnt_in;
        tx_ptr <= '0;
        rx_ptr <= IDX_W'(txn_new);
      end else begin
        if (tx_go) tx_ptr <= tx_last ? '0 : tx_ptr + 1'b1;
        if (rx_go) rx_ptr <= rx_last ? IDX_W'(txn) : rx_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BD; i++) begin
        stat_q[i] <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      if (reg_wr && tbl_hit) begin
        if (reg_addr[2]) addr_q[tbl_idx] <= reg_wdata;
        else             stat_q[tbl_idx] <= reg_wdata;
      end
      if (tx_go) stat_q[tx_ptr] <= {tx_stat[31:16], 1'b0, tx_stat[14:9], tx_result};
      if (rx_go) stat_q[rx_ptr] <= {rx_len, 1'b0, rx_stat[14:9], rx_status};
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (tbl_hit) reg_rdata = reg_addr[2] ? addr_q[tbl_idx] : stat_q[tbl_idx];
    else if (reg_addr == 11'h000) reg_rdata = {27'b0, src_q};
    else if (reg_addr == 11'h004) reg_rdata = {27'b0, mask_q};
    else if (reg_addr == 11'h008) reg_rdata = {24'b0, cnt_q};
  end
endmodule

// File: rtl/bdring_seq_chk.sv
module bdring_seq_chk #(
  parameter int NUM_BD = 16,
  localparam int IDX_W = $clog2(NUM_BD)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [10:0]      reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             tx_done,
  input logic             tx_ready,
  input logic [IDX_W-1:0] tx_index,
  input logic             rx_done,
  input logic             rx_ready,
  input logic [IDX_W-1:0] rx_index,
  input logic [4:0]       src_q,
  input logic [7:0]       txn
);
  wire cnt_wr = reg_wr && (reg_addr == 11'h008);

  p_busy_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_ready |=> src_q[4]);

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_ready && !cnt_wr |=> $stable(rx_index));

  p_tx_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !tx_ready && !cnt_wr |=> $stable(tx_index));

  p_tx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txn != 8'd0 |-> 8'(tx_index) < txn);

  p_rx_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txn < 8'(NUM_BD) |-> 8'(rx_index) >= txn);

  p_w1c_r13: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 11'h000 && reg_wdata[0] && !tx_done |=> !src_q[0]);
endmodule

bind bdring_seq bdring_seq_chk #(.NUM_BD(NUM_BD)) u_chk (.*);

// File: tb/bdring_seq_test.sv
module bdring_seq_test;
  localparam int NUM_BD = 16;
  localparam int IDX_W  = $clog2(NUM_BD);

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [10:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_ready, rx_ready, irq;
  logic [31:0] tx_buf_addr, rx_buf_addr;
  logic [15:0] tx_len;
  logic [1:0] tx_flags;
  logic [IDX_W-1:0] tx_index, rx_index;
  logic tx_done = 0, rx_done = 0;
  logic [8:0] tx_result = '0, rx_status = '0;
  logic [15:0] rx_len = '0;

  always #10 clk = ~clk;

  bdring_seq #(.NUM_BD(NUM_BD)) uut (.*);

  int checks = 0, fails = 0;
  bit mon_go = 0, finished = 0;
  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return reg_rdata;
      1: return 32'(irq);
      2: return 32'(tx_ready);
      3: return 32'(rx_ready);
      4: return 32'(tx_index);
      5: return 32'(rx_index);
      6: return tx_buf_addr;
      7: return 32'(tx_len);
      8: return rx_buf_addr;
      default: return 32'(tx_flags);
    endcase
  endfunction

  always @(negedge clk) begin
    if (mon_go) begin
      while (q_sel.size() > 0) begin
        int s;
        logic [31:0] e, a;
        string t;
        s = q_sel.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        a = pick(s);
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  task automatic push(int sel, logic [31:0] e, string t);
    q_sel.push_back(sel); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic flush();
    mon_go = 1;
    @(negedge clk); #1 mon_go = 0;
  endtask

  task automatic rd_chk(logic [10:0] a, logic [31:0] e, string t);
    reg_addr = a;
    push(0, e, t);
    flush();
  endtask

  task automatic wr(logic [10:0] a, logic [31:0] d);
    @(posedge clk); #1 reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic set_bd(int i, logic [31:0] st, logic [31:0] ad);
    wr(11'h400 + 11'(8 * i), st);
    wr(11'h404 + 11'(8 * i), ad);
  endtask

  task automatic tx_pulse(logic [8:0] r);
    @(posedge clk); #1 tx_done = 1; tx_result = r;
    @(posedge clk); #1 tx_done = 0;
  endtask

  task automatic rx_pulse(logic [15:0] l, logic [8:0] s);
    @(posedge clk); #1 rx_done = 1; rx_len = l; rx_status = s;
    @(posedge clk); #1 rx_done = 0;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    push(1, 0, "R1 irq"); push(2, 0, "R1 tx_ready");
    push(4, 0, "R1 tx_index"); push(5, 0, "R1 rx_index");
    flush();
    rd_chk(11'h000, 0, "R1 source");
    rd_chk(11'h004, 0, "R1 mask");
    rd_chk(11'h008, 0, "R1 count");

    // R2 clamp and pointer placement
    wr(11'h008, 32'h200);
    rd_chk(11'h008, 32'h80, "R2 clamp");
    wr(11'h008, 4);
    push(4, 0, "R2 tx_index"); push(5, 4, "R2 rx_index"); flush();
    wr(11'h004, 32'h1F);

    // R3/R4 transmit descriptor view
    set_bd(0, 32'h0064_C800, 32'h1000);
    rd_chk(11'h400, 32'h0064_C800, "R3 status word");
    rd_chk(11'h404, 32'h1000, "R3 address word");
    push(2, 1, "R4 tx_ready"); push(6, 32'h1000, "R4 tx_buf_addr");
    push(7, 100, "R4 tx_len"); push(9, 1, "R4 tx_flags"); flush();

    // R5/R6/R7 clean completion with irq enable
    tx_pulse(9'h0F2);
    push(1, 1, "R6 irq"); push(4, 1, "R7 advance"); flush();
    rd_chk(11'h400, 32'h0064_48F2, "R5 status writeback");
    rd_chk(11'h000, 32'h1, "R6 frame source");
    wr(11'h000, 32'h1);
    push(1, 0, "R13 irq after clear"); flush();
    rd_chk(11'h000, 0, "R13 w1c");

    // R6 no irq enable
    set_bd(1, 32'h003C_9000, 32'h2000);
    push(9, 2, "R4 pad flag"); flush();
    tx_pulse(9'h100);
    rd_chk(11'h408, 32'h003C_1100, "R5 underrun writeback");
    rd_chk(11'h000, 0, "R6 no source without enable");

    // R6 error, R7 wrap bit
    set_bd(2, 32'h0010_E000, 32'h3000);
    tx_pulse(9'h004);
    rd_chk(11'h000, 32'h2, "R6 error source");
    rd_chk(11'h410, 32'h0010_6004, "R5 late collision writeback");
    push(4, 0, "R7 wrap bit"); push(2, 0, "R12 nothing ready"); flush();

    // R12 ignored pulse
    tx_pulse(9'h001);
    push(4, 0, "R12 pointer held"); flush();
    rd_chk(11'h000, 32'h2, "R12 source held");
    rd_chk(11'h400, 32'h0064_48F2, "R12 table held");
    wr(11'h000, 32'h1F);

    // R7 last-entry wrap
    wr(11'h008, 2);
    push(5, 2, "R2 rx_index at count"); flush();
    set_bd(0, 32'h0008_8000, 32'h1000);
    set_bd(1, 32'h0008_8000, 32'h2000);
    tx_pulse(9'h0);
    push(4, 1, "R7 step"); flush();
    tx_pulse(9'h0);
    push(4, 0, "R7 last entry wrap"); flush();

    // R8/R9/R10 receive
    set_bd(2, 32'h0000_C000, 32'h8000);
    set_bd(3, 32'h0000_E000, 32'h9000);
    push(3, 1, "R8 rx_ready"); push(8, 32'h8000, "R8 rx_buf_addr"); flush();
    rx_pulse(16'h0040, 9'h010);
    rd_chk(11'h410, 32'h0040_4010, "R8 rx writeback");
    rd_chk(11'h000, 32'h4, "R9 frame source");
    push(5, 3, "R10 step"); flush();
    rx_pulse(16'h05EE, 9'h002);
    rd_chk(11'h418, 32'h05EE_6002, "R8 rx crc writeback");
    rd_chk(11'h000, 32'hC, "R9 error source");
    push(5, 2, "R10 wrap to first rx"); flush();
    wr(11'h000, 32'h1F);

    // R11 busy
    push(3, 0, "R11 no empty"); flush();
    rx_pulse(16'h0005, 9'h001);
    rd_chk(11'h000, 32'h10, "R11 busy source");
    push(5, 2, "R11 pointer held"); push(1, 1, "R13 irq busy"); flush();
    rd_chk(11'h410, 32'h0040_4010, "R11 table held");
    wr(11'h004, 32'h0F);
    push(1, 0, "R13 masked"); flush();
    wr(11'h000, 32'h1F);

    // R10 last-entry wrap
    wr(11'h008, 14);
    push(5, 14, "R2 rx_index 14"); flush();
    set_bd(14, 32'h0000_8000, 32'hA000);
    set_bd(15, 32'h0000_8000, 32'hB000);
    rx_pulse(16'h0020, 9'h080);
    push(5, 15, "R10 step to last"); flush();
    rx_pulse(16'h0020, 9'h080);
    push(5, 14, "R10 last entry wrap"); flush();
    rd_chk(11'h470, 32'h0020_0080, "R8 no-enable writeback");
    rd_chk(11'h000, 0, "R9 no source without enable");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule